// File: doc/BRIEF.md
# I2C Controller Data-Request and Event Flag Unit

This unit sits between the host side and the bit-level engine of an I2C controller. It holds a transmit byte FIFO that the host fills and the engine empties, and a receive byte FIFO that the engine fills and the host empties. When a transfer starts it loads a 16-bit count of the bytes left to move. Every byte the engine moves over the bus lowers that count by one.

From the FIFO levels, the remaining count and two programmable thresholds, the unit raises data-request flags. A "ready" flag asks the host for a full threshold-sized burst. A separate "draining" flag fires when the bytes still outstanding cannot make up a whole burst, so the last short burst is still serviced. Completion, no-acknowledge and lost-arbitration events from the engine, and a transmit overflow, are latched beside them. All flags are write-one-to-clear. A single interrupt line is the OR of the flags that pass an enable mask. The bit engine itself is out of scope and is represented by simple byte pop and push handshakes.

Top module: `i2c_fifo_flags`

## Requirements
- R1: After reset, `status`, `irq` and `bytes_left` are 0, `cfg_rdata` reads 0 (both thresholds 1), both FIFOs are empty, `eng_tx_ready` is 0 and `host_rx_data` is 0.
- R2: A `start` pulse loads `start_len` into `bytes_left` and latches the direction (`start_rd`=1 receive). The engine handshake is accepted only in the matching direction, with `bytes_left` nonzero and the FIFO not empty (transmit) or not full (receive). Each accepted byte lowers `bytes_left` by one and moves bytes in first-in first-out order.
- R3: A host push into a full transmit FIFO is dropped and sets the sticky overflow flag `status[7]`.
- R4: Transmit-ready `status[0]` is raised in transmit direction when the TX level is below the TX threshold and need ≥ threshold. Here need = `bytes_left` − TX level, or 0 when that would be negative.
- R5: Transmit-draining `status[1]` is raised instead of `status[0]` when the TX level is below the threshold and 0 < need < threshold. The two are never raised together.
- R6: Receive-ready `status[2]` is raised in receive direction when the RX level is at least the RX threshold.
- R7: Receive-draining `status[3]` is raised in receive direction when `bytes_left` is 0 and 0 < RX level < RX threshold.
- R8: Access-ready `status[4]` is set by the edge that moves the last byte, so it is visible in the same cycle that `bytes_left` reads 0. `eng_nack` sets `status[5]` and `eng_arb_lost` sets `status[6]`.
- R9: A `stat_clr_wr` clears each status bit whose `stat_clr_mask` bit is 1, unless its condition holds in that same cycle. Bits with mask 0 are unchanged, and no bit falls without a clear.
- R10: `irq` is the OR of `status & irq_en` and follows a change of `irq_en` in the same cycle.
- R11: A `cfg_wr` stores the TX threshold minus 1 from `cfg_wdata[5:0]` and the RX threshold minus 1 from `cfg_wdata[13:8]`. Bit 6 empties the TX FIFO and bit 14 empties the RX FIFO. These flush bits are not stored and read back as 0 in `cfg_rdata`.
- R12: `depth_code` is n, where the FIFO depth is 8 << n bytes. `host_rx_data` is 0 while the RX FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer: load count and direction |
| start_rd | input | 1 | Direction of the new transfer, 1 = receive |
| start_len | input | 16 | Byte count of the new transfer |
| cfg_wr | input | 1 | Write strobe for the buffer configuration word |
| cfg_wdata | input | 16 | Threshold fields and flush bits |
| cfg_rdata | output | 16 | Stored thresholds, flush bits read as 0 |
| host_tx_push | input | 1 | Host writes one byte to the TX FIFO |
| host_tx_data | input | 8 | Byte written by the host |
| host_rx_pop | input | 1 | Host removes one byte from the RX FIFO |
| host_rx_data | output | 8 | Head of the RX FIFO, 0 when empty |
| eng_tx_pop | input | 1 | Engine takes one byte for the bus |
| eng_tx_ready | output | 1 | A transmit byte may be taken |
| eng_tx_data | output | 8 | Head of the TX FIFO |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_ready | output | 1 | A received byte may be delivered |
| eng_nack | input | 1 | No-acknowledge event pulse |
| eng_arb_lost | input | 1 | Arbitration-lost event pulse |
| stat_clr_wr | input | 1 | Write-one-to-clear strobe |
| stat_clr_mask | input | 8 | Bits to clear |
| irq_en | input | 8 | Interrupt enable mask |
| status | output | 8 | Latched flags |
| irq | output | 1 | Interrupt request |
| bytes_left | output | 16 | Bytes still to move over the bus |
| depth_code | output | 2 | FIFO depth code n, depth = 8 << n |

## Verification
The bench sweeps every threshold against transfer lengths from one byte to beyond the FIFO depth in both directions. At each step it clears the flags and compares what comes back with flags computed from a level and count model. The sweep catches a draining condition tested against the raw count instead of the count minus the FIFO level: such a design would request bytes that are already queued. It also catches an off-by-one in the threshold-minus-one encoding, which would move every ready edge by one byte. Receive draining while bytes are still expected would be caught, as would an access-ready that comes one cycle late. Directed cases check that a ninth push into a full FIFO neither enters the FIFO nor goes unflagged. They check that a flush empties only the intended FIFO, that a partial write-one-to-clear leaves the other flags standing, and that the enable mask gates the interrupt.

// File: rtl/i2cf_pkg.sv
// Shared constants of the I2C data-request flag unit: status bit positions
// and buffer-configuration field positions. Assumes an 8-bit status word.
package i2cf_pkg;
    localparam int STAT_W   = 8;
    localparam int CNT_W    = 16;
    localparam int THR_W    = 6;

    // status bit positions
    localparam int ST_XRDY  = 0;
    localparam int ST_XDR   = 1;
    localparam int ST_RRDY  = 2;
    localparam int ST_RDR   = 3;
    localparam int ST_ARDY  = 4;
    localparam int ST_NACK  = 5;
    localparam int ST_AL    = 6;
    localparam int ST_TXOVF = 7;

    // buffer configuration word fields
    localparam int CF_TXTHR_LO = 0;
    localparam int CF_TXFLUSH  = 6;
    localparam int CF_RXTHR_LO = 8;
    localparam int CF_RXFLUSH  = 14;
endpackage

// File: rtl/i2cf_byte_fifo.sv
// Byte FIFO with show-ahead head output and a flush that wins over push/pop.
// Assumes DEPTH is a power of two; a push when full or a pop when empty
// is ignored by this module (the caller flags it if needed).
module i2cf_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    // storage write, no reset needed on the data array
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + LW'(push_ok) - LW'(pop_ok);
        end
    end

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (level == LW'(DEPTH)));
    p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
endmodule

// File: rtl/i2cf_xfer_count.sv
// Remaining-byte counter and direction latch of one transfer.
// Assumes `move` is only asserted while the count is nonzero; a start
// in the same cycle as a move reloads the count.
module i2cf_xfer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_rd,
    input  logic [CNT_W-1:0] start_len,
    input  logic             move,
    output logic [CNT_W-1:0] bytes_left,
    output logic             rd_dir,
    output logic             last_move
);
    assign last_move = move && !start && (bytes_left == CNT_W'(1));

    // load on start, count down per byte moved
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_left <= '0;
            rd_dir     <= 1'b0;
        end else if (start) begin
            bytes_left <= start_len;
            rd_dir     <= start_rd;
        end else if (move) begin
            bytes_left <= bytes_left - 1'b1;
        end
    end

    p_move_needs_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        move |-> (bytes_left != '0));
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && move) |=> (bytes_left == $past(bytes_left) - CNT_W'(1)));
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !move) |=> $stable(bytes_left));
endmodule

// File: rtl/i2cf_status_bank.sv
// Write-one-to-clear status register with enable-masked interrupt.
// Assumes `set` carries level conditions and event pulses; set beats clear.
module i2cf_status_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] irq_en,
    output logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;
    assign irq     = |(status & irq_en);

    // latch set bits, drop cleared ones unless re-set
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_eff) | set;
    end

    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((status & $past(clr_mask & ~set)) == '0));
    p_no_silent_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/i2c_fifo_flags.sv
// I2C data-request and event flag unit: TX/RX byte FIFOs, remaining byte
// count, threshold ready/draining flags, event flags, interrupt.
// Assumes DEPTH is 8, 16, 32 or 64 and the engine honours the ready outputs.
module i2c_fifo_flags
    import i2cf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH) + 1,
    localparam int DCODE = $clog2(DEPTH / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [CNT_W-1:0]  start_len,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              host_tx_push,
    input  logic [7:0]        host_tx_data,
    input  logic              host_rx_pop,
    output logic [7:0]        host_rx_data,
    input  logic              eng_tx_pop,
    output logic              eng_tx_ready,
    output logic [7:0]        eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [7:0]        eng_rx_data,
    output logic              eng_rx_ready,
    input  logic              eng_nack,
    input  logic              eng_arb_lost,
    input  logic              stat_clr_wr,
    input  logic [STAT_W-1:0] stat_clr_mask,
    input  logic [STAT_W-1:0] irq_en,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic [CNT_W-1:0]  bytes_left,
    output logic [1:0]        depth_code
);
    logic [THR_W-1:0] tx_thr_m1, rx_thr_m1;
    logic             tx_flush, rx_flush;
    logic [7:0]       tx_head, rx_head;
    logic [LW-1:0]    tx_level, rx_level;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             move_tx, move_rx, rd_dir, last_move;
    logic [CNT_W-1:0] tx_lvl_w, rx_lvl_w, tx_thr_w, rx_thr_w, tx_need;
    logic             xrdy_c, xdr_c, rrdy_c, rdr_c;
    logic [STAT_W-1:0] set_vec;

    assign depth_code = 2'(DCODE);

    // threshold configuration, flush bits act only in the write cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_m1 <= '0;
            rx_thr_m1 <= '0;
        end else if (cfg_wr) begin
            tx_thr_m1 <= cfg_wdata[CF_TXTHR_LO +: THR_W];
            rx_thr_m1 <= cfg_wdata[CF_RXTHR_LO +: THR_W];
        end
    end

    assign tx_flush  = cfg_wr && cfg_wdata[CF_TXFLUSH];
    assign rx_flush  = cfg_wr && cfg_wdata[CF_RXFLUSH];
    assign cfg_rdata = {2'b00, rx_thr_m1, 2'b00, tx_thr_m1};

    i2cf_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(host_tx_push), .push_data(host_tx_data), .pop(move_tx),
        .head(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    i2cf_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(move_rx), .push_data(eng_rx_data), .pop(host_rx_pop),
        .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    i2cf_xfer_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
        .start_len(start_len), .move(move_tx || move_rx),
        .bytes_left(bytes_left), .rd_dir(rd_dir), .last_move(last_move)
    );

    // engine handshakes gated by direction, count and FIFO room
    assign eng_tx_ready = !rd_dir && (bytes_left != '0) && !tx_empty && !tx_flush;
    assign eng_rx_ready = rd_dir && (bytes_left != '0) && !rx_full && !rx_flush;
    assign move_tx      = eng_tx_pop && eng_tx_ready;
    assign move_rx      = eng_rx_push && eng_rx_ready;
    assign eng_tx_data  = tx_empty ? 8'h00 : tx_head;
    assign host_rx_data = rx_empty ? 8'h00 : rx_head;

    // threshold comparisons on a common width
    always_comb begin
        tx_lvl_w = CNT_W'(tx_level);
        rx_lvl_w = CNT_W'(rx_level);
        tx_thr_w = CNT_W'(tx_thr_m1) + CNT_W'(1);
        rx_thr_w = CNT_W'(rx_thr_m1) + CNT_W'(1);
        tx_need  = (bytes_left > tx_lvl_w) ? (bytes_left - tx_lvl_w) : '0;
        xrdy_c   = !rd_dir && (tx_lvl_w < tx_thr_w) && (tx_need >= tx_thr_w);
        xdr_c    = !rd_dir && (tx_lvl_w < tx_thr_w) && (tx_need != '0)
                   && (tx_need < tx_thr_w);
        rrdy_c   = rd_dir && (rx_lvl_w >= rx_thr_w);
        rdr_c    = rd_dir && (bytes_left == '0) && (rx_lvl_w != '0)
                   && (rx_lvl_w < rx_thr_w);
    end

    // gather conditions and events into the set vector
    always_comb begin
        set_vec           = '0;
        set_vec[ST_XRDY]  = xrdy_c;
        set_vec[ST_XDR]   = xdr_c;
        set_vec[ST_RRDY]  = rrdy_c;
        set_vec[ST_RDR]   = rdr_c;
        set_vec[ST_ARDY]  = last_move;
        set_vec[ST_NACK]  = eng_nack;
        set_vec[ST_AL]    = eng_arb_lost;
        set_vec[ST_TXOVF] = host_tx_push && tx_full;
    end

    i2cf_status_bank #(.W(STAT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .set(set_vec), .clr_wr(stat_clr_wr),
        .clr_mask(stat_clr_mask), .irq_en(irq_en), .status(status), .irq(irq)
    );

    p_tx_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(xrdy_c && xdr_c));
    p_ardy_on_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        last_move |=> (status[ST_ARDY] && bytes_left == '0));
    p_rx_draining_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_RDR] && !$past(status[ST_RDR]) |-> $past(bytes_left) == '0);
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_tx_push && tx_full) |=> status[ST_TXOVF]);
endmodule

// File: tb/test_i2c_fifo_flags.sv
`timescale 1ns/1ps
module test_i2c_fifo_flags;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, start_rd;
    logic [15:0] start_len;
    logic        cfg_wr;
    logic [15:0] cfg_wdata, cfg_rdata;
    logic        host_tx_push, host_rx_pop;
    logic [7:0]  host_tx_data, host_rx_data;
    logic        eng_tx_pop, eng_tx_ready, eng_rx_push, eng_rx_ready;
    logic [7:0]  eng_tx_data, eng_rx_data;
    logic        eng_nack, eng_arb_lost, stat_clr_wr, irq;
    logic [7:0]  stat_clr_mask, irq_en, status;
    logic [15:0] bytes_left;
    logic [1:0]  depth_code;

    i2c_fifo_flags #(.DEPTH(DEPTH)) i_i2c_fifo_flags (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
        .start_len(start_len), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .host_tx_push(host_tx_push),
        .host_tx_data(host_tx_data), .host_rx_pop(host_rx_pop),
        .host_rx_data(host_rx_data), .eng_tx_pop(eng_tx_pop),
        .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_rx_ready(eng_rx_ready), .eng_nack(eng_nack),
        .eng_arb_lost(eng_arb_lost), .stat_clr_wr(stat_clr_wr),
        .stat_clr_mask(stat_clr_mask), .irq_en(irq_en), .status(status),
        .irq(irq), .bytes_left(bytes_left), .depth_code(depth_code)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_lvl, m_left, m_thr;
    bit m_rd;

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // flag model from level, count and threshold
    function automatic logic [3:0] exp_dreq();
        int need;
        logic [3:0] e;
        need = (m_left > m_lvl) ? m_left - m_lvl : 0;
        e[0] = !m_rd && m_lvl < m_thr && need >= m_thr;
        e[1] = !m_rd && m_lvl < m_thr && need > 0 && need < m_thr;
        e[2] = m_rd && m_lvl >= m_thr;
        e[3] = m_rd && m_left == 0 && m_lvl > 0 && m_lvl < m_thr;
        return e;
    endfunction

    // clear all flags, then compare what the live conditions re-raise
    task automatic snapshot(string req);
        stat_clr_wr = 1'b1; stat_clr_mask = 8'hFF;
        cyc();
        stat_clr_wr = 1'b0; stat_clr_mask = 8'h00;
        chk(req, "dreq flags", 32'(status[3:0]), 32'(exp_dreq()));
        chk("R9", "events after clear", 32'(status[7:4]), 32'h0);
        chk("R10", "irq", 32'(irq), 32'(|status));
    endtask

    task automatic set_thr(int t);
        cfg_wr = 1'b1;
        cfg_wdata = {2'b00, 6'(t - 1), 2'b00, 6'(t - 1)};
        cyc();
        cfg_wr = 1'b0; cfg_wdata = '0;
        m_thr = t;
    endtask

    task automatic start_xfer(bit rd, int len);
        start = 1'b1; start_rd = rd; start_len = 16'(len);
        cyc();
        start = 1'b0;
        m_rd = rd; m_left = len; m_lvl = 0;
        chk("R2", "count load", 32'(bytes_left), 32'(len));
    endtask

    task automatic host_push(logic [7:0] d);
        host_tx_push = 1'b1; host_tx_data = d;
        cyc();
        host_tx_push = 1'b0;
    endtask

    initial begin
        rst_n = 0; start = 0; start_rd = 0; start_len = 0; cfg_wr = 0;
        cfg_wdata = 0; host_tx_push = 0; host_tx_data = 0; host_rx_pop = 0;
        eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0; eng_nack = 0;
        eng_arb_lost = 0; stat_clr_wr = 0; stat_clr_mask = 0; irq_en = 8'hFF;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        chk("R1", "status", 32'(status), 32'h0);
        chk("R1", "irq", 32'(irq), 32'h0);
        chk("R1", "bytes_left", 32'(bytes_left), 32'h0);
        chk("R1", "cfg_rdata", 32'(cfg_rdata), 32'h0);
        chk("R1", "eng_tx_ready", 32'(eng_tx_ready), 32'h0);
        chk("R1", "host_rx_data", 32'(host_rx_data), 32'h0);
        chk("R12", "depth_code", 32'(depth_code), 32'h0);

        // transmit sweep, R4 R5 R2 R8
        for (int t = 1; t <= DEPTH; t++) begin
            for (int len = 1; len <= 12; len++) begin
                int pushed, popped, fill;
                set_thr(t);
                start_xfer(0, len);
                chk("R2", "rx refused in tx", 32'(eng_rx_ready), 32'h0);
                pushed = 0; popped = 0; fill = 0;
                while (m_left > 0) begin
                    snapshot("R4 R5");
                    if (m_lvl == 0 && pushed < len) begin
                        fill = t + (len % 3);
                        if (fill > len - pushed) fill = len - pushed;
                        if (fill > DEPTH) fill = DEPTH;
                    end
                    if (fill > 0) begin
                        host_push(8'(pushed * 7 + len));
                        pushed++; m_lvl++; fill--;
                    end else begin
                        chk("R2", "tx ready", 32'(eng_tx_ready), 32'h1);
                        chk("R2", "tx order", 32'(eng_tx_data), 32'(8'(popped * 7 + len)));
                        eng_tx_pop = 1'b1;
                        cyc();
                        eng_tx_pop = 1'b0;
                        popped++; m_lvl--; m_left--;
                        chk("R2", "count step", 32'(bytes_left), 32'(m_left));
                        if (m_left == 0)
                            chk("R8", "ardy on last", 32'(status[4]), 32'h1);
                    end
                end
                snapshot("R5");
            end
        end

        // receive sweep, R6 R7 R2 R8 R12
        for (int t = 1; t <= DEPTH; t++) begin
            for (int len = 1; len <= 12; len++) begin
                int got, rd_cnt;
                set_thr(t);
                start_xfer(1, len);
                chk("R2", "tx refused in rx", 32'(eng_tx_ready), 32'h0);
                got = 0; rd_cnt = 0;
                while (m_left > 0 || m_lvl > 0) begin
                    snapshot("R6 R7");
                    if (m_left > 0 && m_lvl < DEPTH && !(m_lvl >= t && (len % 2) == 1)) begin
                        chk("R2", "rx ready", 32'(eng_rx_ready), 32'h1);
                        eng_rx_push = 1'b1; eng_rx_data = 8'(got * 5 + t);
                        cyc();
                        eng_rx_push = 1'b0;
                        got++; m_lvl++; m_left--;
                        if (m_left == 0)
                            chk("R8", "ardy on last rx", 32'(status[4]), 32'h1);
                    end else begin
                        chk("R2", "rx order", 32'(host_rx_data), 32'(8'(rd_cnt * 5 + t)));
                        host_rx_pop = 1'b1;
                        cyc();
                        host_rx_pop = 1'b0;
                        rd_cnt++; m_lvl--;
                    end
                end
                chk("R12", "empty rx reads 0", 32'(host_rx_data), 32'h0);
                snapshot("R7");
            end
        end

        // overflow, R3
        set_thr(4);
        start_xfer(0, 20);
        for (int j = 0; j < DEPTH + 1; j++) host_push(8'(8'hA0 + j));
        chk("R3", "ovf flag", 32'(status[7]), 32'h1);
        chk("R10", "irq on ovf", 32'(irq), 32'h1);
        for (int j = 0; j < DEPTH; j++) begin
            chk("R3", "kept byte", 32'(eng_tx_data), 32'(8'(8'hA0 + j)));
            eng_tx_pop = 1'b1;
            cyc();
            eng_tx_pop = 1'b0;
        end
        chk("R3", "dropped byte absent", 32'(eng_tx_ready), 32'h0);
        m_left = 20 - DEPTH; m_lvl = 0;
        chk("R3", "ovf sticky", 32'(status[7]), 32'h1);
        snapshot("R3");

        // flush and field positions, R11
        for (int j = 0; j < 3; j++) host_push(8'(j));
        m_lvl = 3;
        snapshot("R11");
        cfg_wr = 1'b1; cfg_wdata = 16'h0343;
        cyc();
        cfg_wr = 1'b0;
        m_lvl = 0;
        chk("R11", "tx flushed", 32'(eng_tx_ready), 32'h0);
        chk("R11", "flush bit reads 0", 32'(cfg_rdata), 32'h0303);
        start_xfer(1, 5);
        m_thr = 4;
        for (int j = 0; j < 2; j++) begin
            eng_rx_push = 1'b1; eng_rx_data = 8'h55;
            cyc();
            eng_rx_push = 1'b0;
        end
        m_left = 3; m_lvl = 2;
        cfg_wr = 1'b1; cfg_wdata = 16'h4501;
        cyc();
        cfg_wr = 1'b0;
        m_lvl = 0;
        chk("R11", "rx flushed", 32'(host_rx_data), 32'h0);
        chk("R11", "fields", 32'(cfg_rdata), 32'h0501);
        m_thr = 6;
        snapshot("R11");

        // events, mask and partial clear, R8 R9 R10
        irq_en = 8'h00;
        eng_nack = 1'b1;
        cyc();
        eng_nack = 1'b0;
        chk("R8", "nack flag", 32'(status[5]), 32'h1);
        chk("R10", "masked irq", 32'(irq), 32'h0);
        irq_en = 8'h20; #1;
        chk("R10", "enabled irq", 32'(irq), 32'h1);
        irq_en = 8'h40; #1;
        chk("R10", "other bit enabled", 32'(irq), 32'h0);
        eng_arb_lost = 1'b1;
        cyc();
        eng_arb_lost = 1'b0;
        chk("R8", "al flag", 32'(status[6]), 32'h1);
        chk("R10", "al irq", 32'(irq), 32'h1);
        stat_clr_wr = 1'b1; stat_clr_mask = 8'h20;
        cyc();
        stat_clr_wr = 1'b0;
        chk("R9", "nack cleared", 32'(status[5]), 32'h0);
        chk("R9", "al kept", 32'(status[6]), 32'h1);
        stat_clr_wr = 1'b1; stat_clr_mask = 8'h00;
        cyc();
        stat_clr_wr = 1'b0;
        chk("R9", "zero mask keeps", 32'(status[6]), 32'h1);
        irq_en = 8'hFF;
        snapshot("R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule